// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and gives each attached processor one 4-bit interrupt level. A line's number is its priority, so the level a processor sees is the number of the highest request that is active for it. A request is active when it is pending or forced, and that processor's mask lets it through. Each level also comes with a trap-type code, which is the level plus 0x10.

Software uses a 32-bit word-addressed register bus. Through it software can read the pending vector and read or set the forced vector. A clear register removes pending and forced state without a read-modify-write. Each processor has its own mask word. A processor acknowledges the level it takes, and the controller drops that source's forced state, or its pending state if it was not forced, in the same clock edge. Bit n of every register word stands for source n, and bit 0 is reserved.

Top module: `pic_top`

## Requirements
- R1: After reset the pending, forced and mask registers read 0, and every processor level and trap code is 0.
- R2: A 0-to-1 change on request line n (1..15) sets pending bit n at the next rising clock edge. A line that stays high does not set the bit again once it has been cleared.
- R3: Writing offset 1 ORs bits 15:1 of the written word into the forced vector, and reading offset 1 returns the forced vector.
- R4: Writing offset 2 clears every pending bit and every forced bit whose bit is 1 in the written word. Reading offset 2 returns 0.
- R5: Processor k has its own mask at offset 4+k. A mask bit of 1 lets that source reach processor k, and 0 blocks it.
- R6: The level of processor k (cpu_lvl bits 4k+3:4k) is the highest n for which (pending or forced) and mask k bit n are set. It is 0 when no such n exists.
- R7: An acknowledge from processor k with a nonzero level L clears forced bit L if that bit is set, and otherwise clears pending bit L, at that clock edge. An acknowledge with level 0 changes nothing.
- R8: Bit 0 is reserved in the pending, forced and mask registers. It reads as 0, ignores writes, and request line 0 has no effect.
- R9: When a rising request edge and a clear of the same bit arrive in the same cycle, the bit ends up pending.
- R10: Read data is registered. It appears on bus_rdata in the cycle after a read strobe and is 0 in other cycles. Offsets 3 and 4+NUM_CPU and above read 0, and writes to offset 0 are ignored.
- R11: The trap code of processor k (cpu_trap bits 8k+7:8k) is 0x10 plus its level when the level is nonzero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Request lines; bit n is source n, bit 0 unused |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_ack | input | NUM_CPU | Acknowledge strobe, one per processor |
| cpu_ack_lvl | input | 4*NUM_CPU | Acknowledged level, 4 bits per processor |
| cpu_lvl | output | 4*NUM_CPU | Presented interrupt level, 4 bits per processor |
| cpu_trap | output | 8*NUM_CPU | Trap-type code, 8 bits per processor |

## Verification
The bench builds the block with the default of two processors. With two processors, one active vector can be checked against two different masks at the same time, showing that a source blocked for one processor still reaches the other. Two processors also leave mask offsets 6 and above unmapped, so reads there must return zero. The directed scenarios cover acknowledge ordering between forced and pending state, and same-cycle collisions of an edge with a clear.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NSRC   = 15;
    localparam int VEC_W  = NSRC + 1;
    localparam int LVL_W  = $clog2(VEC_W);
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int TRAP_W = 8;
    localparam logic [TRAP_W-1:0] TRAP_BASE = 8'h10;

    typedef logic [VEC_W-1:0] vec_t;

    localparam vec_t SRC_MASK = ~vec_t'(1);

    typedef enum logic [ADDR_W-1:0] {
        OFF_PEND  = 4'd0,
        OFF_FORCE = 4'd1,
        OFF_CLEAR = 4'd2,
        OFF_MASK0 = 4'd4
    } reg_off_e;

    typedef struct packed {
        vec_t              pend;
        vec_t              frc;
        logic [DATA_W-1:0] rdata;
    } core_state_t;

    function automatic vec_t lvl_onehot(input logic [LVL_W-1:0] lvl);
        vec_t v;
        v = '0;
        v[lvl] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/pic_edge_detect.sv
module pic_edge_detect
    import pic_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = req;
        rise   = req & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc
    import pic_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int LW = LVL_W
) (
    input  logic [W-1:0]  active,
    output logic [LW-1:0] lvl
);
    // Ascending scan: the last hit (highest index) wins; index 0 is never a level.
    always_comb begin
        lvl = '0;
        for (int i = 1; i < W; i++) begin
            if (active[i]) lvl = LW'(i);
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  vec_t                     irq_rise,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic [NUM_CPU-1:0]       cpu_ack,
    input  logic [NUM_CPU*LVL_W-1:0] cpu_ack_lvl,
    output vec_t                     pend,
    output vec_t                     frc,
    output logic [NUM_CPU*VEC_W-1:0] mask_flat,
    output logic [DATA_W-1:0]        rdata
);
    core_state_t st_d, st_q;
    logic [NUM_CPU-1:0][VEC_W-1:0] mask_d, mask_q;

    vec_t clr_v, setf_v, ack_pclr, ack_fclr;
    logic wr_en, rd_en;

    always_comb begin
        st_d     = st_q;
        mask_d   = mask_q;
        clr_v    = '0;
        setf_v   = '0;
        ack_pclr = '0;
        ack_fclr = '0;
        wr_en    = bus_sel && bus_wr;
        rd_en    = bus_sel && !bus_wr;

        // Acknowledge: forced state is consumed before pending state.
        for (int k = 0; k < NUM_CPU; k++) begin
            if (cpu_ack[k] && (cpu_ack_lvl[k*LVL_W +: LVL_W] != '0)) begin
                if ((st_q.frc & lvl_onehot(cpu_ack_lvl[k*LVL_W +: LVL_W])) != '0)
                    ack_fclr = ack_fclr | lvl_onehot(cpu_ack_lvl[k*LVL_W +: LVL_W]);
                else
                    ack_pclr = ack_pclr | lvl_onehot(cpu_ack_lvl[k*LVL_W +: LVL_W]);
            end
        end

        if (wr_en && (bus_addr == OFF_CLEAR)) clr_v  = bus_wdata[VEC_W-1:0];
        if (wr_en && (bus_addr == OFF_FORCE)) setf_v = bus_wdata[VEC_W-1:0];

        // Sets are applied after clears so a same-cycle set survives.
        st_d.pend = ((st_q.pend & ~clr_v & ~ack_pclr) | irq_rise) & SRC_MASK;
        st_d.frc  = ((st_q.frc  & ~clr_v & ~ack_fclr) | setf_v)   & SRC_MASK;

        for (int k = 0; k < NUM_CPU; k++) begin
            if (wr_en && (int'(bus_addr) == int'(OFF_MASK0) + k))
                mask_d[k] = bus_wdata[VEC_W-1:0] & SRC_MASK;
        end

        st_d.rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFF_PEND:  st_d.rdata = DATA_W'(st_q.pend);
                OFF_FORCE: st_d.rdata = DATA_W'(st_q.frc);
                default:   st_d.rdata = '0;
            endcase
            for (int k = 0; k < NUM_CPU; k++) begin
                if (int'(bus_addr) == int'(OFF_MASK0) + k)
                    st_d.rdata = DATA_W'(mask_q[k]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            mask_q <= '0;
        end else begin
            st_q   <= st_d;
            mask_q <= mask_d;
        end
    end

    assign pend      = st_q.pend;
    assign frc       = st_q.frc;
    assign mask_flat = mask_q;
    assign rdata     = st_q.rdata;
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [VEC_W-1:0]          irq_req,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_CPU-1:0]        cpu_ack,
    input  logic [NUM_CPU*LVL_W-1:0]  cpu_ack_lvl,
    output logic [NUM_CPU*LVL_W-1:0]  cpu_lvl,
    output logic [NUM_CPU*TRAP_W-1:0] cpu_trap
);
    vec_t                     irq_rise;
    vec_t                     pend, frc;
    logic [NUM_CPU*VEC_W-1:0] mask_flat;

    pic_edge_detect #(.W(VEC_W)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req),
        .rise  (irq_rise)
    );

    pic_core #(.NUM_CPU(NUM_CPU)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_rise    (irq_rise),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cpu_ack     (cpu_ack),
        .cpu_ack_lvl (cpu_ack_lvl),
        .pend        (pend),
        .frc         (frc),
        .mask_flat   (mask_flat),
        .rdata       (bus_rdata)
    );

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        vec_t              active;
        logic [LVL_W-1:0]  lvl;

        assign active = (pend | frc) & mask_flat[k*VEC_W +: VEC_W];

        pic_prio_enc #(.W(VEC_W), .LW(LVL_W)) enc_i (
            .active (active),
            .lvl    (lvl)
        );

        assign cpu_lvl[k*LVL_W +: LVL_W]    = lvl;
        assign cpu_trap[k*TRAP_W +: TRAP_W] = (lvl == '0) ? '0 : (TRAP_BASE + TRAP_W'(lvl));
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
    import pic_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input vec_t                     irq_rise,
    input vec_t                     pend,
    input vec_t                     frc,
    input logic [NUM_CPU*VEC_W-1:0] mask_flat,
    input logic [NUM_CPU*LVL_W-1:0] cpu_lvl,
    input logic [NUM_CPU-1:0]       cpu_ack,
    input logic [NUM_CPU*LVL_W-1:0] cpu_ack_lvl,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata
);
    logic wr_clear, wr_force;
    assign wr_clear = bus_sel && bus_wr && (bus_addr == OFF_CLEAR);
    assign wr_force = bus_sel && bus_wr && (bus_addr == OFF_FORCE);

    // R8
    rsv_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0] && !frc[0]);

    // R2
    edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rise[VEC_W-1:1] != '0) |=>
        ((pend[VEC_W-1:1] & $past(irq_rise[VEC_W-1:1])) == $past(irq_rise[VEC_W-1:1])));

    // R4
    clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clear |=> ((pend & $past(bus_wdata[VEC_W-1:0]) & ~$past(irq_rise)) == '0));

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_chk
        logic [LVL_W-1:0] lv;
        logic [LVL_W-1:0] alv;
        vec_t             act;
        vec_t             aoh;
        assign lv  = cpu_lvl[k*LVL_W +: LVL_W];
        assign alv = cpu_ack_lvl[k*LVL_W +: LVL_W];
        assign act = (pend | frc) & mask_flat[k*VEC_W +: VEC_W];
        assign aoh = lvl_onehot(alv);

        // R6
        level_is_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lv != '0) |-> ((act >> lv) == vec_t'(1)));

        // R6
        level_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lv == '0) |-> (act[VEC_W-1:1] == '0));

        // R7
        ack_takes_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_ack[k] && (alv != '0) && ((frc & aoh) != '0) &&
             !(wr_force && ((bus_wdata[VEC_W-1:0] & aoh) != '0)))
            |=> ((frc & $past(aoh)) == '0));
    end
endmodule

bind pic_top pic_chk #(.NUM_CPU(NUM_CPU)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_rise    (irq_rise),
    .pend        (pend),
    .frc         (frc),
    .mask_flat   (mask_flat),
    .cpu_lvl     (cpu_lvl),
    .cpu_ack     (cpu_ack),
    .cpu_ack_lvl (cpu_ack_lvl),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata)
);

// File: tb/pic_top_tb_top.sv
module pic_top_tb_top;
    localparam int NCPU = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       irq_req = '0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   cpu_ack = '0;
    logic [NCPU*4-1:0] cpu_ack_lvl = '0;
    logic [NCPU*4-1:0] cpu_lvl;
    logic [NCPU*8-1:0] cpu_trap;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pic_top #(.NUM_CPU(NCPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_ack(cpu_ack), .cpu_ack_lvl(cpu_ack_lvl),
        .cpu_lvl(cpu_lvl), .cpu_trap(cpu_trap)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        irq_req[n] = v;
        @(negedge clk);
    endtask

    task automatic do_ack(input int cpu, input logic [3:0] l);
        @(negedge clk);
        cpu_ack[cpu] = 1'b1;
        cpu_ack_lvl[cpu*4 +: 4] = l;
        @(negedge clk);
        cpu_ack = '0;
        cpu_ack_lvl = '0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read(4'd0, r); chk("R1", "pending", r, 32'h0);
        bus_read(4'd1, r); chk("R1", "forced", r, 32'h0);
        bus_read(4'd4, r); chk("R1", "mask0", r, 32'h0);
        bus_read(4'd5, r); chk("R1", "mask1", r, 32'h0);
        chk("R1", "levels", 32'(cpu_lvl), 32'h0);
        chk("R1", "traps", 32'(cpu_trap), 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] r;
        bus_write(4'd4, 32'hFFFE);
        set_line(5, 1'b1);
        bus_read(4'd0, r); chk("R2", "pending after edge", r, 32'h20);
        chk("R6", "cpu0 level", 32'(cpu_lvl[3:0]), 32'd5);
        chk("R11", "cpu0 trap", 32'(cpu_trap[7:0]), 32'h15);
        chk("R5", "cpu1 blocked", 32'(cpu_lvl[7:4]), 32'd0);
        chk("R11", "cpu1 trap idle", 32'(cpu_trap[15:8]), 32'h0);
        bus_write(4'd2, 32'h20);
        bus_read(4'd0, r); chk("R4", "pending cleared", r, 32'h0);
        repeat (3) @(negedge clk);
        bus_read(4'd0, r); chk("R2", "held line no re-set", r, 32'h0);
        chk("R6", "cpu0 idle", 32'(cpu_lvl[3:0]), 32'd0);
        set_line(5, 1'b0);
    endtask

    task automatic t_prio();
        @(negedge clk);
        irq_req[3] = 1'b1; irq_req[9] = 1'b1;
        @(negedge clk);
        chk("R6", "highest wins", 32'(cpu_lvl[3:0]), 32'd9);
        bus_write(4'd4, 32'hFDFE);
        chk("R5", "mask hides 9", 32'(cpu_lvl[3:0]), 32'd3);
        bus_write(4'd5, 32'h0008);
        chk("R5", "cpu1 own mask", 32'(cpu_lvl[7:4]), 32'd3);
        chk("R11", "cpu1 trap", 32'(cpu_trap[15:8]), 32'h13);
        @(negedge clk);
        irq_req[3] = 1'b0; irq_req[9] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_force();
        logic [31:0] r;
        bus_write(4'd1, 32'h4000);
        bus_read(4'd1, r); chk("R3", "forced readback", r, 32'h4000);
        chk("R6", "forced level cpu0", 32'(cpu_lvl[3:0]), 32'd14);
        chk("R5", "forced masked cpu1", 32'(cpu_lvl[7:4]), 32'd3);
        bus_write(4'd1, 32'h0400);
        bus_read(4'd1, r); chk("R3", "force ORs", r, 32'h4400);
        bus_write(4'd2, 32'h4400);
        bus_read(4'd1, r); chk("R4", "forced cleared", r, 32'h0);
        chk("R6", "level after clear", 32'(cpu_lvl[3:0]), 32'd3);
        bus_read(4'd2, r); chk("R4", "clear reads 0", r, 32'h0);
    endtask

    task automatic t_ack();
        logic [31:0] r;
        bus_write(4'd4, 32'hFFFE);
        bus_write(4'd1, 32'h0200);
        chk("R6", "level 9", 32'(cpu_lvl[3:0]), 32'd9);
        do_ack(0, 4'd9);
        bus_read(4'd1, r); chk("R7", "force taken first", r, 32'h0);
        bus_read(4'd0, r); chk("R7", "pending kept", r, 32'h208);
        do_ack(0, 4'd9);
        bus_read(4'd0, r); chk("R7", "pending taken", r, 32'h008);
        chk("R7", "level drops to 3", 32'(cpu_lvl[3:0]), 32'd3);
        do_ack(1, 4'd0);
        bus_read(4'd0, r); chk("R7", "ack level 0 inert", r, 32'h008);
        do_ack(1, 4'd3);
        bus_read(4'd0, r); chk("R7", "cpu1 ack", r, 32'h0);
        chk("R6", "all idle", 32'(cpu_lvl), 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] r;
        bus_write(4'd1, 32'h0001);
        bus_read(4'd1, r); chk("R8", "force bit0", r, 32'h0);
        bus_write(4'd5, 32'hFFFF);
        bus_read(4'd5, r); chk("R8", "mask bit0", r, 32'hFFFE);
        set_line(0, 1'b1);
        bus_read(4'd0, r); chk("R8", "line 0", r, 32'h0);
        chk("R8", "line 0 level", 32'(cpu_lvl[7:4]), 32'd0);
        set_line(0, 1'b0);
    endtask

    task automatic t_setwins();
        logic [31:0] r;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h40;
        irq_req[6] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(4'd0, r); chk("R9", "edge beats clear", r, 32'h40);
        bus_write(4'd2, 32'h40);
        bus_read(4'd0, r); chk("R9", "later clear", r, 32'h0);
        set_line(6, 1'b0);
    endtask

    task automatic t_bus();
        logic [31:0] r;
        bus_read(4'd3, r); chk("R10", "offset 3", r, 32'h0);
        bus_read(4'd6, r); chk("R10", "unused mask slot", r, 32'h0);
        set_line(2, 1'b1);
        bus_write(4'd0, 32'h0);
        bus_read(4'd0, r); chk("R10", "pending write ignored", r, 32'h4);
        @(negedge clk);
        chk("R10", "idle rdata", bus_rdata, 32'h0);
        bus_write(4'd2, 32'h4);
        set_line(2, 1'b0);
        bus_write(4'd0, 32'hFFFE);
        bus_read(4'd0, r); chk("R10", "pending write no set", r, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_prio();
        t_force();
        t_ack();
        t_reserved();
        t_setwins();
        t_bus();
        finish_run();
    end

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule